// File: doc/BRIEF.md
# Magnetometer Measurement Mode Sequencer

This block is the control engine that decides when a three-axis magnetometer takes its readings. A two-bit operating mode, a three-bit output-rate code and a two-bit bias selector are held in local registers that the host bus writes. From these the sequencer asks an ADC for conversions over a start/done handshake, combines the returned samples into signed results and writes them into the result registers. When a one-shot reading finishes, the sequencer rewrites the mode register to sleep. An internal rate timer, scaled from the `CLK_HZ` parameter, paces free-running operation.

In self-test bias operation every measurement takes two acquisitions. The first is flagged with `adc_set` and has no strap bias. The second carries the selected bias polarity. The stored value is the second sample minus the first. Host bus activity always comes first: while `bus_busy` is high, no new measurement begins and the result registers stay unchanged.

Results leave the block through `res_valid` and `res_data`. This output has no back-pressure. `res_valid` is high for one cycle in the cycle the registers take new values, and `res_data` holds those values until the next update. A consumer that needs flow control latches the data on the pulse.

Top module: `msq_sequencer`

## Requirements
- R1: After reset the mode register reads 10 (idle), the rate code reads 100, the bias selector reads 00, all results read 0, and no conversion is requested while the mode stays idle.
- R2: Mode 00 is free-running. The first conversion request comes exactly 2·P clock cycles after the edge that samples a mode or configuration write, and each later request comes P cycles after the previous one. P is CLK_HZ·10/T, where T is 5, 10, 20, 50, 100, 200 or 500 for rate codes 000 through 110.
- R3: With rate code 111 in free-running mode, no conversion is ever requested.
- R4: In mode 10 (idle) and mode 11 (sleep) no conversion is requested, and a stray `adc_done` leaves the results and `res_valid` untouched.
- R5: Writing mode 01 starts exactly one measurement. When its result is stored, the mode register becomes 11 and no further requests follow.
- R6: Channel c of `adc_data` is bits [12c+11:12c] and channel c of `res_data` is bits [16c+15:16c], with x = 0, y = 1 and z = 2. Without bias, a result is its 12-bit sample sign-extended to 16 bits. A channel whose `adc_ovf` bit is set stores 0xF000 (-4096).
- R7: With bias code 01 or 10, a measurement makes two acquisitions. The first has `adc_set` = 1 and `adc_bias` = 00. The second has `adc_bias` equal to the bias code. The stored value is second minus first. If the difference falls outside -2048..2047, or if either acquisition flags overflow, the channel stores 0xF000. Bias code 11 behaves as 00.
- R8: While `bus_busy` is high no measurement starts and no result is stored. The deferred action takes place on the first cycle after `bus_busy` falls.
- R9: A mode or configuration write during an acquisition abandons it with no result stored. Pacing then restarts at 2·P.
- R10: If a bus write to the mode register lands in the same cycle that a one-shot result is stored, the result is still stored and the mode register takes the written value, not sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 2 | Mode value to write |
| cfg_wr | input | 1 | Write strobe for rate code and bias selector |
| cfg_rate | input | 3 | Output-rate code to write |
| cfg_bias | input | 2 | Bias selector to write |
| bus_busy | input | 1 | Host bus transfer in progress; blocks starts and stores |
| mode_q | output | 2 | Current mode register |
| rate_q | output | 3 | Current rate code |
| bias_q | output | 2 | Current bias selector |
| adc_start | output | 1 | One-cycle conversion request |
| adc_set | output | 1 | Marks the set-pulse acquisition of a bias measurement |
| adc_bias | output | 2 | Strap bias to apply during the requested acquisition |
| adc_done | input | 1 | ADC reports samples valid |
| adc_data | input | 36 | Three 12-bit two's-complement samples |
| adc_ovf | input | 3 | Per-channel ADC range overflow |
| res_valid | output | 1 | One-cycle pulse: result registers updated |
| res_data | output | 48 | Three 16-bit results |

## Verification
The bench measures the interval from a write to the first request and the interval between later requests for every rate code. A timer that started at one period, or that was not reloaded on a write, would be off by P or more. Bias measurements are swept over pairs that include full-scale extremes. A subtractor that wraps instead of saturating to 0xF000, or that subtracts in the wrong order, would store a wrong value. Bus-busy stalls are placed both before a start and across the store, and a one-shot completion is made to coincide with a bus mode write. A design that ignored the stall, or let the automatic return to sleep override the host's write, would fail those checks.

// File: rtl/msq_pkg.sv
`timescale 1ns/1ps
package msq_pkg;
  typedef enum logic [1:0] {
    MD_CONT   = 2'b00,
    MD_SINGLE = 2'b01,
    MD_IDLE   = 2'b10,
    MD_SLEEP  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_ACQ1  = 2'd1,
    ST_ACQ2  = 2'd2,
    ST_STORE = 2'd3
  } seq_st_e;

  localparam logic [2:0] RATE_RESET = 3'b100;
  localparam logic [2:0] RATE_NONE  = 3'b111;

  function automatic logic bias_active(input logic [1:0] b);
    return (b == 2'b01) || (b == 2'b10);
  endfunction
endpackage

// File: rtl/msq_rate_timer.sv
`timescale 1ns/1ps
module msq_rate_timer #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] rate,
  output logic       tick
);
  localparam int CW = $clog2(4 * CLK_HZ + 1);

  logic [CW-1:0] cnt, per, limit;
  logic          first;

  always_comb begin
    case (rate)
      3'd0:    per = CW'(2 * CLK_HZ);
      3'd1:    per = CW'(CLK_HZ);
      3'd2:    per = CW'(CLK_HZ / 2);
      3'd3:    per = CW'(CLK_HZ / 5);
      3'd4:    per = CW'(CLK_HZ / 10);
      3'd5:    per = CW'(CLK_HZ / 20);
      3'd6:    per = CW'(CLK_HZ / 50);
      default: per = '0;
    endcase
    limit = first ? ((per << 1) - CW'(1)) : (per - CW'(1));
  end

  assign tick = run && !restart && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      first <= 1'b1;
    end else if (!run || restart) begin
      cnt   <= '0;
      first <= 1'b1;
    end else if (tick) begin
      cnt   <= '0;
      first <= 1'b0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/msq_chan_combine.sv
`timescale 1ns/1ps
module msq_chan_combine #(
  parameter int DW = 12,
  parameter int RW = 16
) (
  input  logic [DW-1:0] d_first,
  input  logic          o_first,
  input  logic [DW-1:0] d_now,
  input  logic          o_now,
  input  logic          bias_on,
  output logic [RW-1:0] result
);
  localparam logic [RW-1:0] OVF = ~RW'((1 << DW) - 1);

  logic [DW:0] diff;
  logic        fits;

  always_comb begin
    diff = {d_now[DW-1], d_now} - {d_first[DW-1], d_first};
    fits = (diff[DW] == diff[DW-1]);
    if (bias_on)
      result = (o_first || o_now || !fits) ? OVF
             : {{(RW-DW){diff[DW-1]}}, diff[DW-1:0]};
    else
      result = o_now ? OVF : {{(RW-DW){d_now[DW-1]}}, d_now};
  end
endmodule

// File: rtl/msq_sequencer.sv
`timescale 1ns/1ps
module msq_sequencer
  import msq_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int NCH    = 3,
  parameter int DW     = 12,
  parameter int RW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_rate,
  input  logic [1:0]        cfg_bias,
  input  logic              bus_busy,
  output logic [1:0]        mode_q,
  output logic [2:0]        rate_q,
  output logic [1:0]        bias_q,
  output logic              adc_start,
  output logic              adc_set,
  output logic [1:0]        adc_bias,
  input  logic              adc_done,
  input  logic [NCH*DW-1:0] adc_data,
  input  logic [NCH-1:0]    adc_ovf,
  output logic              res_valid,
  output logic [NCH*RW-1:0] res_data
);
  seq_st_e           st;
  logic              any_wr, run_cont, tick, pend, start_fire, bias_run;
  logic [NCH*DW-1:0] first_d;
  logic [NCH-1:0]    first_o;
  logic [NCH*RW-1:0] comb_res, hold;

  assign any_wr   = mode_wr || cfg_wr;
  assign run_cont = (mode_q == MD_CONT) && (rate_q != RATE_NONE);
  assign start_fire = (pend || tick) && (st == ST_WAIT) && !bus_busy && !any_wr &&
                      ((mode_q == MD_CONT) || (mode_q == MD_SINGLE));

  msq_rate_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run_cont), .restart(any_wr),
    .rate(rate_q), .tick(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    msq_chan_combine #(.DW(DW), .RW(RW)) u_comb (
      .d_first(first_d[c*DW +: DW]), .o_first(first_o[c]),
      .d_now(adc_data[c*DW +: DW]),  .o_now(adc_ovf[c]),
      .bias_on(bias_run),            .result(comb_res[c*RW +: RW])
    );
  end

  // Host-visible registers; a bus write outranks the automatic return to sleep.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_IDLE;
      rate_q <= RATE_RESET;
      bias_q <= 2'b00;
    end else begin
      if (cfg_wr) begin
        rate_q <= cfg_rate;
        bias_q <= cfg_bias;
      end
      if (mode_wr)
        mode_q <= mode_wdata;
      else if (st == ST_STORE && !bus_busy && mode_q == MD_SINGLE)
        mode_q <= MD_SLEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend <= 1'b0;
    else if (any_wr)     pend <= mode_wr && (mode_wdata == MD_SINGLE);
    else if (start_fire) pend <= 1'b0;
    else if (tick)       pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_WAIT;
      adc_start <= 1'b0;
      adc_set   <= 1'b0;
      adc_bias  <= 2'b00;
      bias_run  <= 1'b0;
      first_d   <= '0;
      first_o   <= '0;
      hold      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      adc_start <= 1'b0;
      adc_set   <= 1'b0;
      res_valid <= 1'b0;
      case (st)
        ST_WAIT: if (start_fire) begin
          adc_start <= 1'b1;
          adc_set   <= bias_active(bias_q);
          adc_bias  <= 2'b00;
          bias_run  <= bias_active(bias_q);
          st        <= ST_ACQ1;
        end
        ST_ACQ1: if (any_wr) begin
          st <= ST_WAIT;
        end else if (adc_done) begin
          first_d <= adc_data;
          first_o <= adc_ovf;
          if (bias_run) begin
            adc_start <= 1'b1;
            adc_bias  <= bias_q;
            st        <= ST_ACQ2;
          end else begin
            hold <= comb_res;
            st   <= ST_STORE;
          end
        end
        ST_ACQ2: if (any_wr) begin
          adc_bias <= 2'b00;
          st       <= ST_WAIT;
        end else if (adc_done) begin
          hold     <= comb_res;
          adc_bias <= 2'b00;
          st       <= ST_STORE;
        end
        default: if (!bus_busy) begin
          res_data  <= hold;
          res_valid <= 1'b1;
          st        <= ST_WAIT;
        end
      endcase
    end
  end
endmodule

// File: rtl/msq_sequencer_chk.sv
`timescale 1ns/1ps
module msq_sequencer_chk #(
  parameter int NCH = 3,
  parameter int DW  = 12,
  parameter int RW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_busy,
  input logic              mode_wr,
  input logic [1:0]        mode_q,
  input logic              adc_start,
  input logic [1:0]        adc_bias,
  input logic              res_valid,
  input logic [NCH*RW-1:0] res_data
);
  localparam logic [RW-1:0] OVF = ~RW'((1 << DW) - 1);

  // R8: a measurement never opens while the host holds the bus
  assert_start_yields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && adc_bias == 2'b00) |-> !$past(bus_busy));

  // R8: results never land while the host holds the bus
  assert_store_yields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !$past(bus_busy));

  // R4: only free-running or one-shot mode may open a measurement
  assert_quiet_modes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && adc_bias == 2'b00) |-> ($past(mode_q) == 2'b00 || $past(mode_q) == 2'b01));

  // R5: a finished one-shot drops to sleep unless the host wrote the mode
  assert_single_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(mode_q) == 2'b01 && !$past(mode_wr)) |-> (mode_q == 2'b11));

  for (genvar c = 0; c < NCH; c++) begin : g_rng
    // R6: every stored value is the overflow code or a sign-extended 12-bit number
    assert_result_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_data[c*RW +: RW] == OVF ||
                     &res_data[c*RW+DW-1 +: RW-DW+1] ||
                     ~|res_data[c*RW+DW-1 +: RW-DW+1]));
  end
endmodule

bind msq_sequencer msq_sequencer_chk #(.NCH(NCH), .DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .mode_wr(mode_wr),
  .mode_q(mode_q), .adc_start(adc_start), .adc_bias(adc_bias),
  .res_valid(res_valid), .res_data(res_data)
);

// File: tb/msq_sequencer_test.sv
`timescale 1ns/1ps
module msq_sequencer_test;
  localparam int HZ = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0, cfg_wr = 1'b0, bus_busy = 1'b0, adc_done = 1'b0;
  logic [1:0]  mode_wdata = 2'b00, cfg_bias = 2'b00;
  logic [2:0]  cfg_rate = 3'b000;
  logic [1:0]  mode_q, bias_q, adc_bias;
  logic [2:0]  rate_q;
  logic        adc_start, adc_set, res_valid;
  logic [35:0] adc_data = '0;
  logic [2:0]  adc_ovf = '0;
  logic [47:0] res_data;

  int n_cmp = 0, n_bad = 0, start_cnt = 0, valid_cnt = 0, acq_idx = 0;
  int s_val[3], m_val[3];
  logic [2:0] s_ovf = '0, m_ovf = '0;
  logic [1:0] rec_bias[2];
  logic       rec_set[2];

  always #2 clk = ~clk;

  msq_sequencer #(.CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .cfg_wr(cfg_wr), .cfg_rate(cfg_rate), .cfg_bias(cfg_bias), .bus_busy(bus_busy),
    .mode_q(mode_q), .rate_q(rate_q), .bias_q(bias_q), .adc_start(adc_start),
    .adc_set(adc_set), .adc_bias(adc_bias), .adc_done(adc_done), .adc_data(adc_data),
    .adc_ovf(adc_ovf), .res_valid(res_valid), .res_data(res_data)
  );

  always @(negedge clk) begin
    if (adc_start) start_cnt++;
    if (res_valid) valid_cnt++;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // ADC model: answers each request two cycles later, set-pulse requests get s_val
  initial begin
    forever begin
      if (adc_start) begin
        automatic bit use_set = adc_set;
        if (acq_idx < 2) begin
          rec_bias[acq_idx] = adc_bias;
          rec_set[acq_idx]  = adc_set;
        end
        acq_idx++;
        tick(); tick();
        for (int c = 0; c < 3; c++)
          adc_data[c*12 +: 12] = use_set ? s_val[c][11:0] : m_val[c][11:0];
        adc_ovf  = use_set ? s_ovf : m_ovf;
        adc_done = 1'b1;
        tick();
        adc_done = 1'b0;
      end else begin
        tick();
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  task automatic wr_mode(input logic [1:0] m);
    mode_wr = 1'b1; mode_wdata = m; tick(); mode_wr = 1'b0;
  endtask

  task automatic wr_cfg(input logic [2:0] r, input logic [1:0] b);
    cfg_wr = 1'b1; cfg_rate = r; cfg_bias = b; tick(); cfg_wr = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      tick();
      if (res_valid) seen = 1;
    end
  endtask

  task automatic wait_start(output int n);
    n = 0;
    do begin tick(); n++; end while (!adc_start && n < 5000);
  endtask

  function automatic logic [15:0] exp_norm(input int v, input bit o);
    return o ? 16'hF000 : v[15:0];
  endfunction

  function automatic logic [15:0] exp_bias(input int a, input int b, input bit o);
    int d = b - a;
    return (o || d < -2048 || d > 2047) ? 16'hF000 : d[15:0];
  endfunction

  function automatic int pick(input int i);
    case (i % 8)
      0: return -2048; 1: return -2047; 2: return -1; 3: return 0;
      4: return 1;     5: return 1000;  6: return 2046; default: return 2047;
    endcase
  endfunction

  function automatic int edge5(input int i);
    case (i)
      0: return -2048; 1: return -1; 2: return 0; 3: return 1; default: return 2047;
    endcase
  endfunction

  function automatic int period(input int r);
    case (r)
      0: return HZ * 2; 1: return HZ; 2: return HZ / 2; 3: return HZ / 5;
      4: return HZ / 10; 5: return HZ / 20; default: return HZ / 50;
    endcase
  endfunction

  initial begin
    bit seen;
    int n, s0, v0;
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (20) tick();
    // R1 reset state
    chk(mode_q == 2'b10, "R1 mode", mode_q, 2);
    chk(rate_q == 3'b100, "R1 rate", rate_q, 4);
    chk(bias_q == 2'b00, "R1 bias", bias_q, 0);
    chk(res_data == '0, "R1 results", res_data, 0);
    chk(start_cnt == 0, "R1 no request", start_cnt, 0);

    // R6 and R5: one-shot sweep in normal configuration
    for (int i = 0; i < 8; i++) begin
      m_val[0] = pick(i); m_val[1] = pick(i + 3); m_val[2] = pick(i + 5);
      m_ovf = (i == 5) ? 3'b010 : (i == 6) ? 3'b101 : 3'b000;
      s0 = start_cnt;
      wr_mode(2'b01);
      wait_valid(seen);
      chk(seen, "R5 result stored", seen, 1);
      for (int c = 0; c < 3; c++)
        chk(res_data[c*16 +: 16] == exp_norm(m_val[c], m_ovf[c]), "R6 channel value",
            res_data[c*16 +: 16], exp_norm(m_val[c], m_ovf[c]));
      tick();
      chk(mode_q == 2'b11, "R5 back to sleep", mode_q, 3);
      repeat (30) tick();
      chk(start_cnt == s0 + 1, "R5 single request", start_cnt - s0, 1);
    end
    m_ovf = '0;

    // R7: bias sweep, difference and saturation
    for (int bsel = 1; bsel <= 2; bsel++) begin
      wr_cfg(3'b100, 2'(bsel));
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++) begin
          automatic int a = edge5(i);
          automatic int b = edge5(j);
          s_val[0] = a; m_val[0] = b;
          s_val[1] = b; m_val[1] = a;
          s_val[2] = 0; m_val[2] = b;
          s_ovf = (i == 2 && j == 3) ? 3'b001 : 3'b000;
          m_ovf = (i == 3 && j == 2) ? 3'b100 : 3'b000;
          acq_idx = 0;
          wr_mode(2'b01);
          wait_valid(seen);
          chk(seen, "R7 result stored", seen, 1);
          for (int c = 0; c < 3; c++)
            chk(res_data[c*16 +: 16] == exp_bias(s_val[c], m_val[c], s_ovf[c] | m_ovf[c]),
                "R7 bias difference", res_data[c*16 +: 16],
                exp_bias(s_val[c], m_val[c], s_ovf[c] | m_ovf[c]));
          if (i == 0 && j == 0) begin
            chk(acq_idx == 2, "R7 two acquisitions", acq_idx, 2);
            chk(rec_set[0] == 1'b1 && rec_bias[0] == 2'b00, "R7 set acquisition",
                {rec_set[0], rec_bias[0]}, 3'b100);
            chk(rec_set[1] == 1'b0 && rec_bias[1] == 2'(bsel), "R7 biased acquisition",
                {rec_set[1], rec_bias[1]}, bsel);
          end
        end
    end
    s_ovf = '0; m_ovf = '0;
    // R7: code 11 acts as normal
    wr_cfg(3'b100, 2'b11);
    m_val[0] = 77; m_val[1] = -5; m_val[2] = 0;
    acq_idx = 0;
    wr_mode(2'b01);
    wait_valid(seen);
    chk(acq_idx == 1, "R7 code 11 single acquisition", acq_idx, 1);
    chk(res_data[15:0] == 16'd77, "R7 code 11 value", res_data[15:0], 77);

    // R2: pacing for every rate code
    for (int r = 0; r < 7; r++) begin
      wr_cfg(3'(r), 2'b00);
      wr_mode(2'b00);
      wait_start(n);
      chk(n == 2 * period(r), "R2 first request", n, 2 * period(r));
      wait_start(n);
      chk(n == period(r), "R2 steady request", n, period(r));
      wr_mode(2'b10);
      repeat (10) tick();
    end

    // R3: unused rate code
    wr_cfg(3'b111, 2'b00);
    s0 = start_cnt;
    wr_mode(2'b00);
    repeat (3000) tick();
    chk(start_cnt == s0, "R3 no request", start_cnt - s0, 0);

    // R4: idle and sleep stay quiet and ignore a stray done
    for (int md = 2; md <= 3; md++) begin
      wr_cfg(3'b110, 2'b00);
      wr_mode(2'b00);
      repeat (50) tick();
      wr_mode(2'(md));
      repeat (5) tick();
      s0 = start_cnt; v0 = valid_cnt;
      repeat (200) tick();
      adc_done = 1'b1; tick(); adc_done = 1'b0;
      repeat (5) tick();
      chk(start_cnt == s0, "R4 no request", start_cnt - s0, 0);
      chk(valid_cnt == v0, "R4 stray done ignored", valid_cnt - v0, 0);
    end

    // R8: bus busy defers start and store
    m_val[0] = 5; m_val[1] = 6; m_val[2] = 7;
    bus_busy = 1'b1;
    s0 = start_cnt;
    wr_mode(2'b01);
    repeat (50) tick();
    chk(start_cnt == s0, "R8 start held", start_cnt - s0, 0);
    bus_busy = 1'b0;
    tick();
    chk(adc_start == 1'b1, "R8 start on release", adc_start, 1);
    bus_busy = 1'b1;
    v0 = valid_cnt;
    repeat (30) tick();
    chk(valid_cnt == v0, "R8 store held", valid_cnt - v0, 0);
    bus_busy = 1'b0;
    tick();
    chk(res_valid == 1'b1 && res_data[47:32] == 16'd7, "R8 store on release",
        res_data[47:32], 7);

    // R9: write during acquisition aborts and restarts pacing
    wr_cfg(3'b110, 2'b00);
    wr_mode(2'b00);
    wait_start(n);
    v0 = valid_cnt;
    wr_cfg(3'b110, 2'b00);
    wait_start(n);
    chk(n == 2 * period(6), "R9 pacing restart", n, 2 * period(6));
    chk(valid_cnt == v0, "R9 aborted result dropped", valid_cnt - v0, 0);
    wr_mode(2'b10);
    repeat (10) tick();

    // R10: bus mode write coincides with one-shot store
    m_val[0] = 9;
    wr_mode(2'b01);
    wait_start(n);
    bus_busy = 1'b1;
    repeat (10) tick();
    v0 = valid_cnt;
    bus_busy = 1'b0; mode_wr = 1'b1; mode_wdata = 2'b10;
    tick();
    mode_wr = 1'b0;
    chk(res_valid == 1'b1 && res_data[15:0] == 16'd9, "R10 result stored", res_data[15:0], 9);
    chk(mode_q == 2'b10, "R10 bus write wins", mode_q, 2);

    summary();
  end
endmodule